// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

This block is the shift half of a small processor's ALU. It accepts a 16-bit operand, a 4-bit shift count and a 3-bit operation code. It returns the operand shifted left or right logically, shifted right arithmetically, or rotated in either direction. All five operations share one left-rotator. The rotator is built from two multiplexer stages: a coarse stage that turns by 0, 4, 8 or 12 places, then a fine stage that turns by 0, 1, 2 or 3. A right-hand operation turns left by the two's complement of the count, so the count taken modulo 16 gives the equivalent left turn.

After the rotator, a mask from a 16-entry table clears the bit positions that a shift has vacated. For the arithmetic shift, the same positions are filled with copies of the operand's sign bit. The result sits in one output register. Requests arrive on a valid/ready input stream and results leave on a valid/ready output stream. A request is taken in any cycle where `in_valid` and `in_ready` are both high. The block drops `in_ready` only while a result is held and the consumer has `out_ready` low. While the output stream is stalled, the held result and `out_valid` do not change. With `out_ready` held high, the block accepts one request in every cycle.

Top module: `shift_unit`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Code 3'b000 shifts left logically by the count, and the low count bits become zero.
- R3: Code 3'b001 shifts right logically by the count, and the high count bits become zero.
- R4: Code 3'b010 shifts right arithmetically by the count, and the high count bits are copies of operand bit 15.
- R5: Code 3'b011 rotates left by the count. Bit i moves to bit (i+count) mod 16.
- R6: Code 3'b100 rotates right by the count. Bit i moves to bit (i-count) mod 16.
- R7: A count of zero returns the operand unchanged for all five operation codes.
- R8: Codes 3'b101, 3'b110 and 3'b111 return the operand unchanged for any count.
- R9: A request accepted at a clock edge is presented with `out_valid` high immediately after that same edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no new request is taken, and `out_data` and `out_valid` hold their values.
- R11: With `out_ready` held high, requests offered on consecutive cycles are all accepted. The results come out in the same order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 3 | Operation code |
| in_amt | input | 4 | Shift or rotate count, 0 to 15 |
| in_data | input | 16 | Operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result |

## Verification
Each operation code is run over all sixteen counts with several operands:
- A single set bit at each end shows whether the rotator moves a bit into the right place.
- An alternating pattern exposes swapped coarse and fine stages.
- 16'h7FFF and 16'h8001 set the sign bit in opposite ways, which separates the arithmetic right shift from the logical one and shows whether bits wrap around or are cleared.
- Random operands cover the remaining cases.

Count zero and the unused codes are tried on their own, because those paths bypass the mask. Stream tests hold `out_ready` low across several cycles and then issue requests back to back, to confirm that results are held and that ordering is kept.

// File: rtl/shift_unit_pkg.sv
`timescale 1ns/1ps
package shift_unit_pkg;
  typedef enum logic [2:0] {
    OP_SLL = 3'b000,
    OP_SRL = 3'b001,
    OP_SRA = 3'b010,
    OP_ROL = 3'b011,
    OP_ROR = 3'b100
  } shift_op_e;

  // true for operations realised as a left turn by the negated count
  function automatic logic is_right_op(input logic [2:0] op);
    return (op == OP_SRL) || (op == OP_SRA) || (op == OP_ROR);
  endfunction
endpackage

// File: rtl/shift_rot_stage.sv
`timescale 1ns/1ps
// One multiplexer stage: rotate left by sel*STEP places.
module shift_rot_stage #(
  parameter int WIDTH = 16,
  parameter int STEP  = 4,
  parameter int SEL_W = 2
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] dout
);
  localparam int NCAND = 1 << SEL_W;

  function automatic logic [WIDTH-1:0] turn_left(input logic [WIDTH-1:0] v, input int s);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[(i + s) % WIDTH] = v[i];
    return r;
  endfunction

  logic [WIDTH-1:0] cand [NCAND];

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    assign cand[k] = turn_left(din, (k * STEP) % WIDTH);
  end

  assign dout = cand[sel];
endmodule

// File: rtl/shift_rotator.sv
`timescale 1ns/1ps
// Two-stage left rotator: coarse steps then fine steps.
module shift_rotator #(
  parameter int WIDTH  = 16,
  parameter int FINE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(WIDTH)-1:0] amt,
  output logic [WIDTH-1:0]         dout
);
  localparam int AMT_W    = $clog2(WIDTH);
  localparam int COARSE_W = AMT_W - FINE_W;
  localparam int COARSE_S = 1 << FINE_W;

  logic [WIDTH-1:0] mid;

  shift_rot_stage #(.WIDTH(WIDTH), .STEP(COARSE_S), .SEL_W(COARSE_W)) u_coarse (
    .din(din), .sel(amt[AMT_W-1:FINE_W]), .dout(mid)
  );

  shift_rot_stage #(.WIDTH(WIDTH), .STEP(1), .SEL_W(FINE_W)) u_fine (
    .din(mid), .sel(amt[FINE_W-1:0]), .dout(dout)
  );

  // R5 R6: a rotation keeps the number of set bits
  rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dout) == $countones(din));

  // R7: a zero count leaves the word as it was
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amt == '0) |-> (dout == din));
endmodule

// File: rtl/shift_mask_rom.sv
`timescale 1ns/1ps
// Table of all-ones shifted left by the count; right mask is its mirror.
module shift_mask_rom #(
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(WIDTH)-1:0] amt,
  output logic [WIDTH-1:0]         lmask,
  output logic [WIDTH-1:0]         rmask
);
  localparam logic [WIDTH-1:0] ONES = '1;

  logic [WIDTH-1:0] tbl [WIDTH];

  for (genvar e = 0; e < WIDTH; e++) begin : g_tbl
    assign tbl[e] = ONES << e;
  end

  assign lmask = tbl[amt];

  for (genvar b = 0; b < WIDTH; b++) begin : g_mirror
    assign rmask[b] = lmask[WIDTH-1-b];
  end

  // R2 R3: the kept field is exactly WIDTH minus count bits
  mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lmask) == (WIDTH - int'(amt)));

  // R2 R3: the far end of each mask is always kept
  mask_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lmask[WIDTH-1] && rmask[0]);
endmodule

// File: rtl/shift_unit.sv
`timescale 1ns/1ps
module shift_unit #(
  parameter int WIDTH  = 16,
  parameter int FINE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [2:0]               in_op,
  input  logic [$clog2(WIDTH)-1:0] in_amt,
  input  logic [WIDTH-1:0]         in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WIDTH-1:0]         out_data
);
  import shift_unit_pkg::*;

  localparam int AMT_W = $clog2(WIDTH);

  logic [AMT_W-1:0] rot_amt;
  logic [WIDTH-1:0] rotated, lmask, rmask, result;
  logic             fire;

  // right-hand operations turn left by (WIDTH - count) mod WIDTH
  assign rot_amt = is_right_op(in_op) ? (~in_amt + 1'b1) : in_amt;

  shift_rotator #(.WIDTH(WIDTH), .FINE_W(FINE_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .din(in_data), .amt(rot_amt), .dout(rotated)
  );

  shift_mask_rom #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .amt(in_amt), .lmask(lmask), .rmask(rmask)
  );

  always_comb begin
    unique case (in_op)
      OP_SLL:  result = rotated & lmask;
      OP_SRL:  result = rotated & rmask;
      OP_SRA:  result = (rotated & rmask) | ({WIDTH{in_data[WIDTH-1]}} & ~rmask);
      OP_ROL,
      OP_ROR:  result = rotated;
      default: result = in_data;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_SRA) |=> (out_data[WIDTH-1] == $past(in_data[WIDTH-1])));

  // R2
  sll_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_SLL && in_amt != '0) |=> !out_data[0]);

  // R3
  srl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_SRL && in_amt != '0) |=> !out_data[WIDTH-1]);
endmodule

// File: tb/shift_unit_bench.sv
`timescale 1ns/1ps
module shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_amt = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_unit u_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_amt(in_amt), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] model(input logic [2:0] op, input logic [3:0] n, input logic [15:0] a);
    logic [31:0] wide;
    logic [15:0] r;
    case (op)
      3'b000: r = a << n;
      3'b001: r = a >> n;
      3'b010: r = 16'($signed(a) >>> n);
      3'b011: begin wide = {a, a} << n; r = wide[31:16]; end
      3'b100: begin wide = {a, a} >> n; r = wide[15:0]; end
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one request with out_ready high; checked right after its accepting edge
  task automatic one_op(input string req, input logic [2:0] op, input logic [3:0] n, input logic [15:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_amt = n; in_data = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {15'd0, out_valid}, 16'd1);
    check(req, out_data, model(op, n, a));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", {15'd0, out_valid}, 16'd0);
    check("R1 in_ready", {15'd0, in_ready}, 16'd1);
  endtask

  task automatic t_sweep(input string req, input logic [2:0] op);
    logic [15:0] pats [5] = '{16'h0001, 16'h8001, 16'hA5C3, 16'h7FFF, 16'h0000};
    for (int n = 0; n < 16; n++) begin
      pats[4] = 16'($urandom);
      for (int p = 0; p < 5; p++) one_op(req, op, 4'(n), pats[p]);
    end
  endtask

  task automatic t_zero_amount;
    for (int op = 0; op < 5; op++) begin
      logic [15:0] a = 16'($urandom) | 16'h8000;
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'(op); in_amt = 4'd0; in_data = a;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 zero count", out_data, a);
    end
  endtask

  task automatic t_unused;
    for (int op = 5; op < 8; op++)
      for (int n = 0; n < 16; n += 5) begin
        logic [15:0] a = 16'($urandom);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op); in_amt = 4'(n); in_data = a;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 unused code", out_data, a);
      end
  endtask

  task automatic t_backpressure;
    logic [15:0] first_exp, second_exp;
    first_exp  = model(3'b010, 4'd3, 16'h9234);
    second_exp = model(3'b100, 4'd7, 16'h1357);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'b010; in_amt = 4'd3; in_data = 16'h9234;
    @(negedge clk);
    in_op = 3'b100; in_amt = 4'd7; in_data = 16'h1357;
    for (int c = 0; c < 3; c++) begin
      check("R10 in_ready low", {15'd0, in_ready}, 16'd0);
      check("R10 held valid", {15'd0, out_valid}, 16'd1);
      check("R10 held data", out_data, first_exp);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 released data", out_data, second_exp);
    @(negedge clk);
    check("R10 drained", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_stream;
    logic [15:0] exp_q [8];
    logic [15:0] prev;
    for (int i = 0; i < 8; i++) begin
      logic [2:0]  op = 3'(i % 5);
      logic [3:0]  n  = 4'(3 * i + 1);
      logic [15:0] a  = 16'($urandom);
      exp_q[i] = model(op, n, a);
      @(negedge clk);
      if (i > 0) check("R11 in order", out_data, prev);
      if (i > 0) check("R9 R11 valid", {15'd0, out_valid}, 16'd1);
      in_valid = 1'b1; in_op = op; in_amt = n; in_data = a;
      prev = exp_q[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 last", out_data, prev);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep("R2 sll", 3'b000);
    t_sweep("R3 srl", 3'b001);
    t_sweep("R4 sra", 3'b010);
    t_sweep("R5 rol", 3'b011);
    t_sweep("R6 ror", 3'b100);
    one_op("R9 latency", 3'b011, 4'd9, 16'h00F0);
    t_zero_amount();
    t_unused();
    t_backpressure();
    t_stream();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule